// File: doc/BRIEF.md
# Reprogrammable Multi-Probe Trigger Unit

The block watches several probe buses, each of its own width, and raises a single trigger bit for a capture controller. Every probe owns a small comparator whose test is chosen at run time by a 4-bit operation code and an argument value. The tests cover magnitude comparisons against the argument, a rising or falling edge on the probe's least significant bit, and any change of the whole probe value. Edge and change tests use a registered copy of the probe from the previous clock.

The comparator results are merged by a gate that a configuration register switches between AND and OR. The same register can hand the output over to an external trigger input, which bypasses the comparators entirely. All settings are held in registers loaded through a simple write port (enable, address, data), so a new trigger condition is a matter of a few writes. The output is registered: a sample presented in one cycle shows its trigger on `trig_o` after the next rising clock edge.

Register map (address: content): 0 holds the combine control, with bit 0 = 1 selecting AND (0 selecting OR) and bit 1 = 1 selecting the external trigger; address 1+2i holds the operation code of probe i in bits [3:0]; address 2+2i holds the argument of probe i. Probe i occupies bits [i*PW +: PW] of `probes_i`; only its low `WIDTHS[8*i +: 8]` bits are meaningful.

Top module: `trig_unit`

## Requirements
- R1: While `rst_n` is low, `trig_o` is 0; reset leaves every probe disabled (op 0), all arguments 0, OR combining and the external trigger deselected, so after reset `trig_o` stays 0 until configured.
- R2: A write with `cfg_we_i` high loads the addressed register at the clock edge; the new setting applies to samples from the following cycle on, while the sample presented in the write cycle is judged with the old setting.
- R3: Op codes 4=GT, 5=LT, 6=GEQ, 7=LEQ, 8=EQ, 9=NEQ compare the probe against its argument as unsigned numbers; both are first cut to the probe's own width, so bits above that width are ignored.
- R4: Op 1 (rising) hits when bit 0 of the probe is 1 now and was 0 in the previous cycle; op 2 (falling) hits on the opposite transition; other bits of the probe have no effect on these tests.
- R5: Op 3 (changing) hits when the probe value, cut to its width, differs from the value of the previous cycle.
- R6: A probe with op 0 is neutral: it counts as a pass in AND mode and as a miss in OR mode; with no probe enabled the internal trigger is 0 in both modes.
- R7: In OR mode the trigger is 1 when any enabled probe hits; in AND mode it is 1 when at least one probe is enabled and every enabled probe hits.
- R8: With the external trigger selected, `trig_o` follows `ext_trig_i` and the comparators are ignored.
- R9: `trig_o` reflects the inputs of the previous cycle: exactly one register lies between the probe and external inputs and the output.
- R10: Op codes 10 to 15 behave like op 0, and writes to addresses above 2*NPROBE change no setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| probes_i | input | NPROBE*PW | Probe buses, probe i in slot i |
| ext_trig_i | input | 1 | External trigger input |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_addr_i | input | AW | Configuration register address |
| cfg_wdata_i | input | PW | Configuration write data |
| trig_o | output | 1 | Registered combined trigger |

## Verification
The two functions that can land in one cycle are a configuration write and a probe event that the new setting would judge differently from the old one. The bench provokes this with directed writes placed on the very cycle a probe reaches its argument or toggles its bit 0, and with random writes spread through a long random run. Its model applies each write only after the clock edge, so the expected trigger for the write cycle comes from the old setting and any mix-up of the two shows as a mismatch on the following cycle.

// File: rtl/trig_pkg.sv
package trig_pkg;

  // Operation codes of a probe comparator (R3, R4, R5, R6)
  typedef enum logic [3:0] {
    OP_OFF  = 4'd0,
    OP_RISE = 4'd1,
    OP_FALL = 4'd2,
    OP_CHG  = 4'd3,
    OP_GT   = 4'd4,
    OP_LT   = 4'd5,
    OP_GE   = 4'd6,
    OP_LE   = 4'd7,
    OP_EQ   = 4'd8,
    OP_NE   = 4'd9
  } trig_op_e;

  localparam int OP_W  = 4;
  localparam int CMP_W = 32;

  typedef logic [CMP_W-1:0] cmp_word_t;

  // Codes 1..9 are live; 0 and 10..15 are neutral (R10)
  function automatic logic op_active(input logic [OP_W-1:0] op);
    return (op >= 4'd1) && (op <= 4'd9);
  endfunction

  // Width mask for a probe of w bits inside a CMP_W word
  function automatic cmp_word_t width_mask(input int w);
    cmp_word_t m;
    m = '0;
    for (int b = 0; b < CMP_W; b++) begin
      if (b < w) m[b] = 1'b1;
    end
    return m;
  endfunction

  // Condition of one probe; operands already cut to probe width
  function automatic logic eval_cond(input logic [OP_W-1:0] op,
                                     input cmp_word_t cur,
                                     input cmp_word_t prev,
                                     input cmp_word_t arg);
    logic r;
    case (op)
      OP_RISE: r = cur[0] & ~prev[0];
      OP_FALL: r = ~cur[0] & prev[0];
      OP_CHG:  r = (cur != prev);
      OP_GT:   r = (cur > arg);
      OP_LT:   r = (cur < arg);
      OP_GE:   r = (cur >= arg);
      OP_LE:   r = (cur <= arg);
      OP_EQ:   r = (cur == arg);
      OP_NE:   r = (cur != arg);
      default: r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/trig_cfg_regs.sv
module trig_cfg_regs
  import trig_pkg::*;
#(
  parameter int NPROBE = 3,
  parameter int PW     = 9,
  parameter int AW     = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we_i,
  input  logic [AW-1:0]                  addr_i,
  input  logic [PW-1:0]                  wdata_i,
  output logic [NPROBE-1:0][OP_W-1:0]    op_o,
  output logic [NPROBE-1:0][PW-1:0]      arg_o,
  output logic                           and_mode_o,
  output logic                           ext_sel_o
);

  localparam logic [AW-1:0] CTRL_ADDR = '0;

  // Combine control register (R2, R1)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      and_mode_o <= 1'b0;
      ext_sel_o  <= 1'b0;
    end else if (we_i && addr_i == CTRL_ADDR) begin
      and_mode_o <= wdata_i[0];
      ext_sel_o  <= wdata_i[1];
    end
  end

  // Per-probe operation and argument registers
  for (genvar i = 0; i < NPROBE; i++) begin : g_probe_regs
    localparam logic [AW-1:0] OP_ADDR  = AW'(1 + 2 * i);
    localparam logic [AW-1:0] ARG_ADDR = AW'(2 + 2 * i);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        op_o[i] <= OP_OFF;
      end else if (we_i && addr_i == OP_ADDR) begin
        op_o[i] <= wdata_i[OP_W-1:0];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        arg_o[i] <= '0;
      end else if (we_i && addr_i == ARG_ADDR) begin
        arg_o[i] <= wdata_i;
      end
    end
  end

endmodule

// File: rtl/probe_cond.sv
module probe_cond
  import trig_pkg::*;
#(
  parameter int W  = 1,
  parameter int PW = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PW-1:0]   sample_i,
  input  logic [OP_W-1:0] op_i,
  input  logic [PW-1:0]   arg_i,
  output logic            hit_o,
  output logic            en_o
);

  localparam cmp_word_t MASK = width_mask(W);

  cmp_word_t cur_w;
  cmp_word_t arg_w;
  cmp_word_t prev_q;

  // Cut operands to the probe's own width (R3, R5)
  assign cur_w = CMP_W'(sample_i) & MASK;
  assign arg_w = CMP_W'(arg_i) & MASK;

  // Previous sample for edge and change tests; cleared by reset (R4, R5)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cur_w;
  end

  assign hit_o = eval_cond(op_i, cur_w, prev_q, arg_w);
  assign en_o  = op_active(op_i);

endmodule

// File: rtl/trig_combine.sv
module trig_combine #(
  parameter int NPROBE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPROBE-1:0] hit_i,
  input  logic [NPROBE-1:0] en_i,
  input  logic              and_mode_i,
  input  logic              ext_sel_i,
  input  logic              ext_i,
  output logic              trig_next_o,
  output logic              trig_o
);

  logic any_en;
  logic all_pass;
  logic any_hit;
  logic internal_trig;

  // Disabled probes are neutral in both gate types (R6, R7)
  always_comb begin
    any_en        = |en_i;
    all_pass      = &(hit_i | ~en_i);
    any_hit       = |(hit_i & en_i);
    internal_trig = and_mode_i ? (any_en & all_pass) : any_hit;
    trig_next_o   = ext_sel_i ? ext_i : internal_trig;
  end

  // Single output register (R9)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_o <= 1'b0;
    else        trig_o <= trig_next_o;
  end

endmodule

// File: rtl/trig_unit.sv
module trig_unit
  import trig_pkg::*;
#(
  parameter int                    NPROBE = 3,
  parameter int                    PW     = 9,
  parameter logic [NPROBE*8-1:0]   WIDTHS = {8'd9, 8'd3, 8'd1},
  parameter int                    AW     = $clog2(2 * NPROBE + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NPROBE*PW-1:0] probes_i,
  input  logic                 ext_trig_i,
  input  logic                 cfg_we_i,
  input  logic [AW-1:0]        cfg_addr_i,
  input  logic [PW-1:0]        cfg_wdata_i,
  output logic                 trig_o
);

  logic [NPROBE-1:0][OP_W-1:0] cfg_op;
  logic [NPROBE-1:0][PW-1:0]   cfg_arg;
  logic                        cfg_and;
  logic                        cfg_ext;
  logic [NPROBE-1:0]           probe_hit;
  logic [NPROBE-1:0]           probe_en;
  logic                        trig_next;

  trig_cfg_regs #(
    .NPROBE (NPROBE),
    .PW     (PW),
    .AW     (AW)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .we_i       (cfg_we_i),
    .addr_i     (cfg_addr_i),
    .wdata_i    (cfg_wdata_i),
    .op_o       (cfg_op),
    .arg_o      (cfg_arg),
    .and_mode_o (cfg_and),
    .ext_sel_o  (cfg_ext)
  );

  for (genvar i = 0; i < NPROBE; i++) begin : g_probe
    localparam int WI = int'(WIDTHS[8*i +: 8]);

    probe_cond #(
      .W  (WI),
      .PW (PW)
    ) u_cond (
      .clk      (clk),
      .rst_n    (rst_n),
      .sample_i (probes_i[i*PW +: PW]),
      .op_i     (cfg_op[i]),
      .arg_i    (cfg_arg[i]),
      .hit_o    (probe_hit[i]),
      .en_o     (probe_en[i])
    );
  end

  trig_combine #(
    .NPROBE (NPROBE)
  ) u_comb (
    .clk         (clk),
    .rst_n       (rst_n),
    .hit_i       (probe_hit),
    .en_i        (probe_en),
    .and_mode_i  (cfg_and),
    .ext_sel_i   (cfg_ext),
    .ext_i       (ext_trig_i),
    .trig_next_o (trig_next),
    .trig_o      (trig_o)
  );

endmodule

// File: rtl/trig_unit_chk.sv
module trig_unit_chk #(
  parameter int NPROBE = 3,
  parameter int PW     = 9,
  parameter int AW     = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ext_trig_i,
  input logic              cfg_we_i,
  input logic [AW-1:0]     cfg_addr_i,
  input logic [PW-1:0]     cfg_wdata_i,
  input logic              trig_o,
  input logic              cfg_and,
  input logic              cfg_ext,
  input logic [NPROBE-1:0] probe_hit,
  input logic [NPROBE-1:0] probe_en
);

  AST_EXT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ext |=> (trig_o == $past(ext_trig_i))); // R8

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_ext && probe_en == '0) |=> !trig_o); // R6

  AST_AND_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_ext && cfg_and && |(probe_en & ~probe_hit)) |=> !trig_o); // R7

  AST_OR_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_ext && !cfg_and && |(probe_en & probe_hit)) |=> trig_o); // R7

  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we_i && cfg_addr_i == '0) |=>
      (cfg_and == $past(cfg_wdata_i[0]) && cfg_ext == $past(cfg_wdata_i[1]))); // R2

endmodule

bind trig_unit trig_unit_chk #(
  .NPROBE (NPROBE),
  .PW     (PW),
  .AW     (AW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ext_trig_i  (ext_trig_i),
  .cfg_we_i    (cfg_we_i),
  .cfg_addr_i  (cfg_addr_i),
  .cfg_wdata_i (cfg_wdata_i),
  .trig_o      (trig_o),
  .cfg_and     (cfg_and),
  .cfg_ext     (cfg_ext),
  .probe_hit   (probe_hit),
  .probe_en    (probe_en)
);

// File: tb/trig_unit_bench.sv
`timescale 1ns/1ps
module trig_unit_bench;

  localparam int NP = 3;
  localparam int PW = 9;
  localparam int AW = 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NP*PW-1:0]  probes_i;
  logic              ext_trig_i;
  logic              cfg_we_i;
  logic [AW-1:0]     cfg_addr_i;
  logic [PW-1:0]     cfg_wdata_i;
  logic              trig_o;

  always #2 clk = ~clk;

  trig_unit u_trig_unit (
    .clk         (clk),
    .rst_n       (rst_n),
    .probes_i    (probes_i),
    .ext_trig_i  (ext_trig_i),
    .cfg_we_i    (cfg_we_i),
    .cfg_addr_i  (cfg_addr_i),
    .cfg_wdata_i (cfg_wdata_i),
    .trig_o      (trig_o)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // Bench model of the configuration and previous samples
  logic [3:0]    m_op   [NP];
  logic [PW-1:0] m_arg  [NP];
  logic [PW-1:0] m_prev [NP];
  bit            m_and;
  bit            m_ext;

  function automatic int wid(int i);
    case (i)
      0: return 1;
      1: return 3;
      default: return 9;
    endcase
  endfunction

  function automatic int fit(int i, logic [PW-1:0] v);
    return int'(v) % (1 << wid(i));
  endfunction

  function automatic logic [PW-1:0] slot(int i);
    return probes_i[i*PW +: PW];
  endfunction

  function automatic bit cond(int i);
    int c, p, a;
    c = fit(i, slot(i));
    p = fit(i, m_prev[i]);
    a = fit(i, m_arg[i]);
    if (m_op[i] == 4'd1) return (c % 2 == 1) && (p % 2 == 0);
    if (m_op[i] == 4'd2) return (c % 2 == 0) && (p % 2 == 1);
    if (m_op[i] == 4'd3) return c != p;
    if (m_op[i] == 4'd4) return c > a;
    if (m_op[i] == 4'd5) return c < a;
    if (m_op[i] == 4'd6) return !(c < a);
    if (m_op[i] == 4'd7) return !(c > a);
    if (m_op[i] == 4'd8) return c == a;
    if (m_op[i] == 4'd9) return c != a;
    return 1'b0;
  endfunction

  function automatic bit expect_trig();
    int n_en, n_hit;
    if (m_ext) return ext_trig_i;
    n_en = 0;
    n_hit = 0;
    for (int i = 0; i < NP; i++) begin
      if (m_op[i] != 0 && m_op[i] < 10) begin
        n_en++;
        if (cond(i)) n_hit++;
      end
    end
    if (m_and) return (n_en > 0) && (n_hit == n_en);
    return n_hit > 0;
  endfunction

  task automatic check(bit act, bit exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: trig_o actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NP; i++) begin
      m_op[i] = '0;
      m_arg[i] = '0;
      m_prev[i] = '0;
    end
    m_and = 1'b0;
    m_ext = 1'b0;
  endtask

  // One clock: expected from pre-edge state, model update, check off-edge
  task automatic cycle(string tag);
    bit exp;
    int idx;
    exp = expect_trig();
    @(posedge clk);
    if (cfg_we_i) begin
      if (cfg_addr_i == 0) begin
        m_and = cfg_wdata_i[0];
        m_ext = cfg_wdata_i[1];
      end else if (int'(cfg_addr_i) <= 2 * NP) begin
        idx = (int'(cfg_addr_i) - 1) / 2;
        if (cfg_addr_i[0]) m_op[idx] = cfg_wdata_i[3:0];
        else               m_arg[idx] = cfg_wdata_i;
      end
    end
    for (int i = 0; i < NP; i++) m_prev[i] = slot(i);
    @(negedge clk);
    check(trig_o, exp, tag);
    cfg_we_i = 1'b0;
  endtask

  task automatic wr(int addr, int data, string tag);
    cfg_we_i = 1'b1;
    cfg_addr_i = AW'(addr);
    cfg_wdata_i = PW'(data);
    cycle(tag);
  endtask

  task automatic setp(int i, int v);
    probes_i[i*PW +: PW] = PW'(v);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #800000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not end, actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    rst_n = 1'b0;
    probes_i = '1;
    ext_trig_i = 1'b1;
    cfg_we_i = 1'b0;
    cfg_addr_i = '0;
    cfg_wdata_i = '0;
    model_reset();

    // R1: output low during reset, inputs active
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(trig_o, 1'b0, "R1");
    end
    rst_n = 1'b1;
    ext_trig_i = 1'b0;

    // R1 / R6: defaults, nothing enabled
    for (int k = 0; k < 4; k++) begin
      probes_i = {$urandom, $urandom};
      cycle("R1");
    end

    // R3: GEQ on the 9-bit probe, boundary around 5
    probes_i = '0;
    wr(5, 6, "R2");
    wr(6, 5, "R2");
    setp(2, 4); cycle("R3");
    setp(2, 5); cycle("R3");
    setp(2, 6); cycle("R3");
    setp(2, 0); cycle("R3");
    wr(5, 0, "R2");

    // R3: EQ on 3-bit probe, upper bits ignored in sample and argument
    wr(3, 8, "R2");
    wr(4, 9'h1F3, "R3");
    setp(1, 9'h10B); cycle("R3");
    setp(1, 2);      cycle("R3");
    setp(1, 3);      cycle("R3");
    wr(3, 7, "R3");      // LEQ
    setp(1, 4);      cycle("R3");

    // R4: rising on bit 0, bit 1 activity must not matter
    wr(3, 1, "R4");
    setp(1, 2); cycle("R4");
    setp(1, 3); cycle("R4");
    setp(1, 3); cycle("R4");
    setp(1, 1); cycle("R4");
    setp(1, 0); cycle("R4");
    wr(3, 2, "R4");      // falling
    setp(1, 1); cycle("R4");
    setp(1, 6); cycle("R4");
    setp(1, 4); cycle("R4");

    // R5: change of whole value, masked to width
    wr(3, 3, "R5");
    setp(1, 4); cycle("R5");
    setp(1, 4); cycle("R5");
    setp(1, 12); cycle("R5");
    setp(1, 8);  cycle("R5");

    // R7 / R6: AND of probe0 EQ 1 and probe1 EQ 3, probe2 disabled
    wr(1, 8, "R7");
    wr(2, 1, "R7");
    wr(3, 8, "R7");
    wr(4, 3, "R7");
    wr(0, 1, "R7");
    setp(0, 1); setp(1, 2); cycle("R7");
    setp(0, 0); setp(1, 3); cycle("R7");
    setp(0, 1); setp(1, 3); cycle("R6");
    setp(0, 1); setp(1, 3); wr(0, 0, "R7");
    setp(0, 0); cycle("R7");

    // R10: invalid codes neutral, unmapped address ignored
    wr(0, 1, "R10");
    wr(1, 12, "R10");
    setp(0, 0); setp(1, 3); cycle("R10");
    wr(7, 9'h1FF, "R10");
    cycle("R10");
    wr(1, 0, "R10");
    wr(3, 0, "R10");
    cycle("R6");

    // R8: external trigger bypasses comparators
    wr(3, 8, "R8");
    wr(0, 2, "R8");
    setp(1, 3);
    ext_trig_i = 1'b0; cycle("R8");
    ext_trig_i = 1'b1; cycle("R9");
    ext_trig_i = 0;    cycle("R8");
    wr(0, 0, "R8");
    cycle("R8");

    // R2: write in the same cycle as a matching sample
    setp(1, 0);
    wr(3, 9, "R2");
    setp(1, 5); wr(4, 5, "R2");
    setp(1, 5); cycle("R2");

    // Random phase
    for (int k = 0; k < 4000; k++) begin
      for (int i = 0; i < NP; i++) begin
        if ($urandom_range(0, 1) == 0) setp(i, $urandom_range(0, 7));
        else setp(i, $urandom_range(0, 511));
      end
      ext_trig_i = $urandom_range(0, 1);
      if ($urandom_range(0, 5) == 0) begin
        cfg_we_i = 1'b1;
        cfg_addr_i = AW'($urandom_range(0, 7));
        if (cfg_addr_i == 0)
          cfg_wdata_i = PW'({($urandom_range(0, 3) == 0), 1'($urandom_range(0, 1))});
        else if (cfg_addr_i[0])
          cfg_wdata_i = PW'($urandom_range(0, 15));
        else
          cfg_wdata_i = PW'($urandom_range(0, 15));
      end
      cycle("R7");
    end

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule